// File: doc/BRIEF.md
# Reuse Instance Recorder

This controller builds one reuse instance after a reuse query has missed. While it is in record mode it watches the stream of retired instructions. It collects the register values the region consumes into an input bank and the live-out results it produces into an output bank. It also notes whether the region touched memory. When the region is left, the recorder either commits the instance into the reuse buffer through a single write port, or drops it.

A miss reports the region's entry number and the least-recently-used instance slot of that entry, taken from the buffer's replacement state. The recorder makes that slot its victim. On the first cycle it invalidates the slot, so a half-built instance can never hit. Retired events then arrive one per cycle, each tagged with a kind, a register index, a value and a live-out mark. The buffer storage and instruction decoding live outside this block.

Top module: `memo_recorder`

## Requirements
- R1: A `missValid` pulse while idle makes `active` high from the next cycle. In that same cycle `wrEn` pulses for one cycle with `wrValid` low, `wrEntry` equal to the captured `missEntry` and `wrSlot` equal to the captured `victimSlot`.
- R2: Entering record mode clears both bank masks, the memory flag and the per-register written tracking. No data from an earlier instance remains.
- R3: A read event (`evKind` 0) of a register not yet written in the region, and not already held in the input bank, takes the next input slot (slot 0 first) with its index and value. A later read of the same register keeps the first value, and a read after a write is not recorded.
- R4: A write event (`evKind` 1) marks its register as written. If `evLiveOut` is set, the register and value go to the next output slot. A repeated live-out write to the same register overwrites that slot's value. A write without the mark is not recorded.
- R5: A load event (`evKind` 2) sets `wrMemDep`, which stays set until the next mode entry.
- R6: An endpoint event (`evKind` 3) produces a one-cycle `wrEn` with `wrValid` high on the next cycle, carrying the banks built so far, and drops `active`.
- R7: An exit event (`evKind` 4) drops `active` on the next cycle with no write, so the victim stays invalid.
- R8: If a ninth distinct input register or a ninth distinct live-out register would be needed, the recorder leaves record mode without a write. Exactly eight of each still commit normally.
- R9: `missValid` while active and any event while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Reuse query missed; start recording |
| missEntry | input | ENTRY_W | Entry number of the region |
| victimSlot | input | SLOT_W | Least-recently-used instance slot of that entry |
| evValid | input | 1 | Retired event present |
| evKind | input | 3 | 0 read, 1 write, 2 load, 3 endpoint, 4 exit |
| evReg | input | REG_W | Register index of the event |
| evData | input | DATA_W | Register value read or written |
| evLiveOut | input | 1 | Write carries the live-out mark |
| active | output | 1 | Record mode in progress |
| wrEn | output | 1 | Buffer write strobe |
| wrValid | output | 1 | Instance valid bit to write |
| wrEntry | output | ENTRY_W | Entry being written |
| wrSlot | output | SLOT_W | Instance slot being written |
| wrMemDep | output | 1 | Instance depends on memory |
| wrInMask | output | IN_SLOTS | Valid bits of the input bank |
| wrInRegs | output | IN_SLOTS*REG_W | Input register indices, slot 0 in the low bits |
| wrInVals | output | IN_SLOTS*DATA_W | Input register values |
| wrOutMask | output | OUT_SLOTS | Valid bits of the output bank |
| wrOutRegs | output | OUT_SLOTS*REG_W | Output register indices |
| wrOutVals | output | OUT_SLOTS*DATA_W | Output result values |

## Verification
The stream in the first test mixes fresh reads, a repeated read with a changed value, a read after a write and a live-out write. This separates correct read-before-write filtering from naive capture of every read. A second stream repeats a live-out write, adds a plain write and a load, and ends at an endpoint, which shows overwrite against reallocation. Exit-terminated and overfilled regions, including the case of exactly full banks, show that commit and discard depend only on the leaving instruction and on capacity. Starts requested during recording and events sent while idle confirm that both are ignored.

// File: rtl/memo_rec_pkg.sv
package memo_rec_pkg;
  typedef enum logic [2:0] {
    EV_READ  = 3'd0,
    EV_WRITE = 3'd1,
    EV_LOAD  = 3'd2,
    EV_END   = 3'd3,
    EV_EXIT  = 3'd4
  } evKind_e;

  typedef struct packed {
    logic clearAll;
    logic addIn;
    logic addOut;
    logic updOut;
    logic markWr;
    logic setMem;
  } strobes_t;
endpackage

// File: rtl/memo_rec_dp.sv
module memo_rec_dp
  import memo_rec_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int DATA_W    = 32,
  parameter int IN_SLOTS  = 8,
  parameter int OUT_SLOTS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  strobes_t                    stb,
  input  logic [REG_W-1:0]            evReg,
  input  logic [DATA_W-1:0]           evData,
  output logic                        isWritten,
  output logic                        inHit,
  output logic                        inFull,
  output logic                        outHit,
  output logic                        outFull,
  output logic                        memDep,
  output logic [IN_SLOTS-1:0]         inMask,
  output logic [IN_SLOTS*REG_W-1:0]   inRegsFlat,
  output logic [IN_SLOTS*DATA_W-1:0]  inValsFlat,
  output logic [OUT_SLOTS-1:0]        outMask,
  output logic [OUT_SLOTS*REG_W-1:0]  outRegsFlat,
  output logic [OUT_SLOTS*DATA_W-1:0] outValsFlat
);
  localparam int NUM_REGS   = 2 ** REG_W;
  localparam int IN_IDX_W   = (IN_SLOTS > 1) ? $clog2(IN_SLOTS) : 1;
  localparam int OUT_IDX_W  = (OUT_SLOTS > 1) ? $clog2(OUT_SLOTS) : 1;
  localparam int IN_CNT_W   = $clog2(IN_SLOTS + 1);
  localparam int OUT_CNT_W  = $clog2(OUT_SLOTS + 1);
  localparam logic [IN_CNT_W-1:0]  IN_LIMIT  = IN_CNT_W'(IN_SLOTS);
  localparam logic [OUT_CNT_W-1:0] OUT_LIMIT = OUT_CNT_W'(OUT_SLOTS);

  logic [NUM_REGS-1:0]  writtenVec;
  logic [REG_W-1:0]     inReg  [IN_SLOTS];
  logic [DATA_W-1:0]    inVal  [IN_SLOTS];
  logic [IN_SLOTS-1:0]  inVld;
  logic [IN_CNT_W-1:0]  inCnt;
  logic [REG_W-1:0]     outReg [OUT_SLOTS];
  logic [DATA_W-1:0]    outVal [OUT_SLOTS];
  logic [OUT_SLOTS-1:0] outVld;
  logic [OUT_CNT_W-1:0] outCnt;
  logic                 memFlag;
  logic [OUT_IDX_W-1:0] outHitIdx;
  logic [IN_IDX_W-1:0]  inNext;
  logic [OUT_IDX_W-1:0] outNext;

  assign inNext    = inCnt[IN_IDX_W-1:0];
  assign outNext   = outCnt[OUT_IDX_W-1:0];
  assign inFull    = (inCnt == IN_LIMIT);
  assign outFull   = (outCnt == OUT_LIMIT);
  assign isWritten = writtenVec[evReg];

  always_comb begin
    inHit = 1'b0;
    for (int i = 0; i < IN_SLOTS; i++)
      if (inVld[i] && inReg[i] == evReg) inHit = 1'b1;
  end

  always_comb begin
    outHit    = 1'b0;
    outHitIdx = '0;
    for (int i = 0; i < OUT_SLOTS; i++)
      if (outVld[i] && outReg[i] == evReg) begin
        outHit    = 1'b1;
        outHitIdx = OUT_IDX_W'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stb.clearAll) begin
      writtenVec <= '0;
      inVld      <= '0;
      inCnt      <= '0;
      outVld     <= '0;
      outCnt     <= '0;
      memFlag    <= 1'b0;
      for (int i = 0; i < IN_SLOTS; i++) begin
        inReg[i] <= '0;
        inVal[i] <= '0;
      end
      for (int i = 0; i < OUT_SLOTS; i++) begin
        outReg[i] <= '0;
        outVal[i] <= '0;
      end
    end else begin
      if (stb.markWr) writtenVec[evReg] <= 1'b1;
      if (stb.setMem) memFlag <= 1'b1;
      if (stb.addIn) begin
        inReg[inNext] <= evReg;
        inVal[inNext] <= evData;
        inVld[inNext] <= 1'b1;
        inCnt         <= inCnt + 1'b1;
      end
      if (stb.addOut) begin
        outReg[outNext] <= evReg;
        outVal[outNext] <= evData;
        outVld[outNext] <= 1'b1;
        outCnt          <= outCnt + 1'b1;
      end
      if (stb.updOut) outVal[outHitIdx] <= evData;
    end
  end

  assign memDep  = memFlag;
  assign inMask  = inVld;
  assign outMask = outVld;

  for (genvar g = 0; g < IN_SLOTS; g++) begin : gInFlat
    assign inRegsFlat[g*REG_W +: REG_W]   = inReg[g];
    assign inValsFlat[g*DATA_W +: DATA_W] = inVal[g];
  end
  for (genvar g = 0; g < OUT_SLOTS; g++) begin : gOutFlat
    assign outRegsFlat[g*REG_W +: REG_W]   = outReg[g];
    assign outValsFlat[g*DATA_W +: DATA_W] = outVal[g];
  end
endmodule

// File: rtl/memo_rec_ctrl.sv
module memo_rec_ctrl
  import memo_rec_pkg::*;
#(
  parameter int ENTRY_W = 4,
  parameter int SLOT_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               missValid,
  input  logic [ENTRY_W-1:0] missEntry,
  input  logic [SLOT_W-1:0]  victimSlot,
  input  logic               evValid,
  input  logic [2:0]         evKind,
  input  logic               evLiveOut,
  input  logic               isWritten,
  input  logic               inHit,
  input  logic               inFull,
  input  logic               outHit,
  input  logic               outFull,
  output strobes_t           stb,
  output logic               active,
  output logic               wrEn,
  output logic               wrValid,
  output logic [ENTRY_W-1:0] wrEntry,
  output logic [SLOT_W-1:0]  wrSlot
);
  logic abortNow, commitNow, exitNow;

  always_comb begin
    stb       = '0;
    abortNow  = 1'b0;
    commitNow = 1'b0;
    exitNow   = 1'b0;
    if (!active) begin
      stb.clearAll = missValid;
    end else if (evValid) begin
      case (evKind)
        EV_READ:
          if (!isWritten && !inHit) begin
            if (inFull) abortNow = 1'b1;
            else        stb.addIn = 1'b1;
          end
        EV_WRITE: begin
          stb.markWr = 1'b1;
          if (evLiveOut) begin
            if (outHit)       stb.updOut = 1'b1;
            else if (outFull) abortNow   = 1'b1;
            else              stb.addOut = 1'b1;
          end
        end
        EV_LOAD: stb.setMem = 1'b1;
        EV_END:  commitNow  = 1'b1;
        EV_EXIT: exitNow    = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      wrEn    <= 1'b0;
      wrValid <= 1'b0;
      wrEntry <= '0;
      wrSlot  <= '0;
    end else begin
      wrEn <= 1'b0;
      if (!active) begin
        if (missValid) begin
          active  <= 1'b1;
          wrEn    <= 1'b1;
          wrValid <= 1'b0;
          wrEntry <= missEntry;
          wrSlot  <= victimSlot;
        end
      end else if (commitNow) begin
        wrEn    <= 1'b1;
        wrValid <= 1'b1;
        active  <= 1'b0;
      end else if (abortNow || exitNow) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/memo_recorder.sv
module memo_recorder
  import memo_rec_pkg::*;
#(
  parameter int ENTRY_W   = 4,
  parameter int SLOT_W    = 2,
  parameter int REG_W     = 5,
  parameter int DATA_W    = 32,
  parameter int IN_SLOTS  = 8,
  parameter int OUT_SLOTS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        missValid,
  input  logic [ENTRY_W-1:0]          missEntry,
  input  logic [SLOT_W-1:0]           victimSlot,
  input  logic                        evValid,
  input  logic [2:0]                  evKind,
  input  logic [REG_W-1:0]            evReg,
  input  logic [DATA_W-1:0]           evData,
  input  logic                        evLiveOut,
  output logic                        active,
  output logic                        wrEn,
  output logic                        wrValid,
  output logic [ENTRY_W-1:0]          wrEntry,
  output logic [SLOT_W-1:0]           wrSlot,
  output logic                        wrMemDep,
  output logic [IN_SLOTS-1:0]         wrInMask,
  output logic [IN_SLOTS*REG_W-1:0]   wrInRegs,
  output logic [IN_SLOTS*DATA_W-1:0]  wrInVals,
  output logic [OUT_SLOTS-1:0]        wrOutMask,
  output logic [OUT_SLOTS*REG_W-1:0]  wrOutRegs,
  output logic [OUT_SLOTS*DATA_W-1:0] wrOutVals
);
  strobes_t stb;
  logic isWritten, inHit, inFull, outHit, outFull;

  memo_rec_ctrl #(.ENTRY_W(ENTRY_W), .SLOT_W(SLOT_W)) uCtrl (
    .clk(clk), .rst_n(rst_n),
    .missValid(missValid), .missEntry(missEntry), .victimSlot(victimSlot),
    .evValid(evValid), .evKind(evKind), .evLiveOut(evLiveOut),
    .isWritten(isWritten), .inHit(inHit), .inFull(inFull),
    .outHit(outHit), .outFull(outFull),
    .stb(stb), .active(active), .wrEn(wrEn), .wrValid(wrValid),
    .wrEntry(wrEntry), .wrSlot(wrSlot)
  );

  memo_rec_dp #(.REG_W(REG_W), .DATA_W(DATA_W),
                .IN_SLOTS(IN_SLOTS), .OUT_SLOTS(OUT_SLOTS)) uDp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .evReg(evReg), .evData(evData),
    .isWritten(isWritten), .inHit(inHit), .inFull(inFull),
    .outHit(outHit), .outFull(outFull), .memDep(wrMemDep),
    .inMask(wrInMask), .inRegsFlat(wrInRegs), .inValsFlat(wrInVals),
    .outMask(wrOutMask), .outRegsFlat(wrOutRegs), .outValsFlat(wrOutVals)
  );
endmodule

// File: rtl/memo_recorder_chk.sv
module memo_recorder_chk #(
  parameter int IN_SLOTS  = 8,
  parameter int OUT_SLOTS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 missValid,
  input logic                 evValid,
  input logic [2:0]           evKind,
  input logic                 active,
  input logic                 wrEn,
  input logic                 wrValid,
  input logic                 wrMemDep,
  input logic [IN_SLOTS-1:0]  wrInMask,
  input logic [OUT_SLOTS-1:0] wrOutMask
);
  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    missValid && !active |=> active && wrEn && !wrValid);

  // R2
  fresh_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && !wrValid |-> wrInMask == '0 && wrOutMask == '0 && !wrMemDep);

  // R5
  load_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && evValid && evKind == 3'd2 |=> wrMemDep);

  // R6
  endpoint_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && evValid && evKind == 3'd3 |=> wrEn && wrValid && !active);

  // R7
  exit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && evValid && evKind == 3'd4 |=> !active && !wrEn);

  // R9
  busy_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    missValid && active |=> !(wrEn && !wrValid));
endmodule

bind memo_recorder memo_recorder_chk #(.IN_SLOTS(IN_SLOTS), .OUT_SLOTS(OUT_SLOTS)) uChk (
  .clk(clk), .rst_n(rst_n), .missValid(missValid), .evValid(evValid),
  .evKind(evKind), .active(active), .wrEn(wrEn), .wrValid(wrValid),
  .wrMemDep(wrMemDep), .wrInMask(wrInMask), .wrOutMask(wrOutMask)
);

// File: tb/sim_memo_recorder.sv
module sim_memo_recorder;
  localparam int ENTRY_W = 4, SLOT_W = 2, REG_W = 5, DATA_W = 32;
  localparam int IN_SLOTS = 8, OUT_SLOTS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic missValid = 1'b0;
  logic [ENTRY_W-1:0] missEntry = '0;
  logic [SLOT_W-1:0] victimSlot = '0;
  logic evValid = 1'b0;
  logic [2:0] evKind = '0;
  logic [REG_W-1:0] evReg = '0;
  logic [DATA_W-1:0] evData = '0;
  logic evLiveOut = 1'b0;
  logic active, wrEn, wrValid, wrMemDep;
  logic [ENTRY_W-1:0] wrEntry;
  logic [SLOT_W-1:0] wrSlot;
  logic [IN_SLOTS-1:0] wrInMask;
  logic [IN_SLOTS*REG_W-1:0] wrInRegs;
  logic [IN_SLOTS*DATA_W-1:0] wrInVals;
  logic [OUT_SLOTS-1:0] wrOutMask;
  logic [OUT_SLOTS*REG_W-1:0] wrOutRegs;
  logic [OUT_SLOTS*DATA_W-1:0] wrOutVals;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  memo_recorder u0 (.*);

  task automatic chkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendEv(input logic [2:0] k, input logic [REG_W-1:0] r,
                        input logic [DATA_W-1:0] d, input logic lo);
    evValid = 1'b1; evKind = k; evReg = r; evData = d; evLiveOut = lo;
    step();
    evValid = 1'b0; evLiveOut = 1'b0;
  endtask

  task automatic startRec(input logic [ENTRY_W-1:0] e, input logic [SLOT_W-1:0] s);
    missValid = 1'b1; missEntry = e; victimSlot = s;
    step();
    missValid = 1'b0;
    chkEq("R1 active", active, 1);
    chkEq("R1 invalidate", {wrEn, wrValid, wrEntry, wrSlot}, {1'b1, 1'b0, e, s});
    chkEq("R2 cleared", {wrInMask, wrOutMask, wrMemDep}, 0);
  endtask

  function automatic logic [REG_W-1:0] inR(input int i);
    return wrInRegs[i*REG_W +: REG_W];
  endfunction
  function automatic logic [DATA_W-1:0] inV(input int i);
    return wrInVals[i*DATA_W +: DATA_W];
  endfunction
  function automatic logic [REG_W-1:0] outR(input int i);
    return wrOutRegs[i*REG_W +: REG_W];
  endfunction
  function automatic logic [DATA_W-1:0] outV(input int i);
    return wrOutVals[i*DATA_W +: DATA_W];
  endfunction

  task automatic testReset();
    chkEq("R1 reset idle", {active, wrEn}, 0);
  endtask

  task automatic testBasic();
    startRec(4'd3, 2'd2);
    step();
    chkEq("R1 single pulse", wrEn, 0);
    sendEv(3'd0, 5'd1, 32'h11, 1'b0);
    sendEv(3'd0, 5'd2, 32'h22, 1'b0);
    sendEv(3'd1, 5'd3, 32'h33, 1'b1);
    sendEv(3'd0, 5'd3, 32'h44, 1'b0);
    sendEv(3'd0, 5'd1, 32'h99, 1'b0);
    sendEv(3'd3, 5'd0, 32'h0, 1'b0);
    chkEq("R6 commit", {wrEn, wrValid, wrEntry, wrSlot, active}, {1'b1, 1'b1, 4'd3, 2'd2, 1'b0});
    chkEq("R3 in mask", wrInMask, 8'h03);
    chkEq("R3 in slot0", {inR(0), inV(0)}, {5'd1, 32'h11});
    chkEq("R3 in slot1", {inR(1), inV(1)}, {5'd2, 32'h22});
    chkEq("R4 out", {wrOutMask, outR(0), outV(0)}, {8'h01, 5'd3, 32'h33});
    chkEq("R5 no load", wrMemDep, 0);
    step();
    chkEq("R6 one pulse", wrEn, 0);
  endtask

  task automatic testOverwrite();
    startRec(4'd7, 2'd1);
    sendEv(3'd1, 5'd6, 32'h1, 1'b1);
    sendEv(3'd1, 5'd6, 32'h2, 1'b1);
    sendEv(3'd1, 5'd7, 32'h5, 1'b0);
    sendEv(3'd0, 5'd7, 32'h6, 1'b0);
    sendEv(3'd2, 5'd0, 32'h0, 1'b0);
    chkEq("R5 load flag", wrMemDep, 1);
    sendEv(3'd3, 5'd0, 32'h0, 1'b0);
    chkEq("R4 overwrite", {wrOutMask, outR(0), outV(0)}, {8'h01, 5'd6, 32'h2});
    chkEq("R3 read after write", wrInMask, 0);
    chkEq("R5 flag kept", {wrEn, wrValid, wrMemDep}, 3'b111);
  endtask

  task automatic testExit();
    startRec(4'd5, 2'd0);
    sendEv(3'd0, 5'd9, 32'hAB, 1'b0);
    sendEv(3'd4, 5'd0, 32'h0, 1'b0);
    chkEq("R7 exit no write", {active, wrEn}, 0);
    step();
    chkEq("R7 still no write", wrEn, 0);
    sendEv(3'd3, 5'd0, 32'h0, 1'b0);
    chkEq("R9 idle event ignored", {active, wrEn}, 0);
  endtask

  task automatic testOverflow();
    startRec(4'd2, 2'd3);
    for (int i = 0; i < IN_SLOTS; i++) sendEv(3'd0, 5'(10 + i), 32'(i), 1'b0);
    chkEq("R8 eight inputs fit", {active, wrInMask}, {1'b1, 8'hFF});
    sendEv(3'd0, 5'd30, 32'h7, 1'b0);
    chkEq("R8 input abort", {active, wrEn}, 0);
    step();
    chkEq("R8 input abort no write", wrEn, 0);
    startRec(4'd2, 2'd3);
    for (int i = 0; i < OUT_SLOTS + 1; i++) sendEv(3'd1, 5'(i), 32'(i), 1'b1);
    chkEq("R8 output abort", {active, wrEn}, 0);
    startRec(4'd6, 2'd1);
    for (int i = 0; i < IN_SLOTS; i++) sendEv(3'd0, 5'(20 + i), 32'(100 + i), 1'b0);
    sendEv(3'd3, 5'd0, 32'h0, 1'b0);
    chkEq("R8 full commit", {wrEn, wrValid, wrInMask}, {2'b11, 8'hFF});
    chkEq("R3 last slot", {inR(7), inV(7)}, {5'd27, 32'd107});
  endtask

  task automatic testBusyMiss();
    startRec(4'd1, 2'd0);
    missValid = 1'b1; missEntry = 4'd9; victimSlot = 2'd3;
    step();
    missValid = 1'b0;
    chkEq("R9 busy miss ignored", {active, wrEn}, 2'b10);
    sendEv(3'd3, 5'd0, 32'h0, 1'b0);
    chkEq("R9 entry kept", {wrEn, wrEntry, wrSlot}, {1'b1, 4'd1, 2'd0});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    testReset();
    testBasic();
    testOverwrite();
    testExit();
    testOverflow();
    testBusyMiss();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule